// File: doc/BRIEF.md
# ALU Status Flag Generator

This block is a purely combinational add, subtract and bitwise-logic unit. It returns a result and five arithmetic status flags for operands that are 8, 16, 32 or 64 bits wide. Both operand buses are always 64 bits wide. A two-bit size code picks the active width. Operand bits above that width are discarded before the operation, and result bits above it are driven low.

The flags are carry, nibble half-carry, zero, sign and signed overflow. Carry, sign and overflow are taken at the top bit of the selected width, not at bit 63. A status register placed after this unit can therefore capture the flags the same way for every operand size. The half-carry flag lets later decimal-adjust logic correct a packed BCD byte without repeating the addition.

Top module: `alu_flag_gen`

## Requirements
- R1: The size code selects the active width: 2'b00 is 8 bits, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 64. Result bits at and above the active width are always 0.
- R2: For opcode 3'b000 (add), the result is the sum of the two operands' low active-width bits, modulo 2 to the active width. Operand bits above the active width have no effect.
- R3: For opcode 3'b001 (subtract), the result is the first operand minus the second, taken over the low active-width bits and modulo 2 to the active width.
- R4: On add, the carry flag is the carry out of the top bit of the active width.
- R5: On subtract, the carry flag is 1 exactly when the first operand's active bits, read as unsigned, are less than the second operand's.
- R6: The half-carry flag is the carry out of bit 3 into bit 4 on add. On subtract it is 1 when bits 3:0 of the first operand, read as unsigned, are less than bits 3:0 of the second.
- R7: The zero flag is 1 exactly when the masked result is all zeros. This holds for every opcode.
- R8: The sign flag equals result bit (active width − 1) for every opcode.
- R9: On add, the overflow flag is 1 when both operands have the same sign at the active width and the result's sign differs from it. For example, an 8-bit add of 0x7F and 0x01 gives 0x80 with overflow set.
- R10: On subtract, the overflow flag is 1 when the operand signs differ and the result's sign differs from the first operand's sign.
- R11: Opcodes 3'b010, 3'b011 and 3'b100 return the bitwise AND, OR and XOR of the masked operands. For these opcodes carry, half-carry and overflow are 0.
- R12: Opcodes 3'b101 to 3'b111 return a zero result with carry, half-carry, sign and overflow at 0 and zero at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand (minuend on subtract) |
| b_i | input | 64 | Second operand (subtrahend on subtract) |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Active operand width code |
| result_o | output | 64 | Result, masked to the active width |
| carry_o | output | 1 | Carry on add, borrow on subtract |
| aux_o | output | 1 | Half-carry or half-borrow across bits 3 and 4 |
| zero_o | output | 1 | Result is all zeros |
| sign_o | output | 1 | Top bit of the result at the active width |
| ovf_o | output | 1 | Signed overflow |

## Verification
The unit holds no state, so any wrong internal value appears at the outputs in the same evaluation as the input that exposes it. The most likely faults are a wrong width mask or a flag tapped at the wrong bit. The first would leak upper operand bits into the result. The second would give a carry, sign or overflow taken from bit 63 or from a neighbouring width. Both show up only for particular operand and size combinations. The bench therefore sweeps every 8-bit operand pair under every opcode, with garbage placed in the unused upper bits. It also drives boundary patterns at 16, 32 and 64 bits against arithmetic reference values.

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  input  logic [1:0]   size_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         aux_o,
  output logic         zero_o,
  output logic         sign_o,
  output logic         ovf_o
);
  localparam int Q = W / 8;

  logic [W-1:0] mask;
  logic [W-1:0] am, bm, res;
  logic [W:0]   add_full, sub_full;
  logic [4:0]   nib_add, nib_sub;
  logic         sa, sb, sr, add_c;

  always_comb begin
    case (size_i)
      2'b00:   mask = {{(W-8){1'b0}}, 8'hFF};
      2'b01:   mask = {{(W-16){1'b0}}, 16'hFFFF};
      2'b10:   mask = {{(W-4*Q){1'b0}}, {(4*Q){1'b1}}};
      default: mask = {W{1'b1}};
    endcase
  end

  assign am = a_i & mask;
  assign bm = b_i & mask;
  assign add_full = {1'b0, am} + {1'b0, bm};
  assign sub_full = {1'b0, am} - {1'b0, bm};
  assign nib_add = {1'b0, am[3:0]} + {1'b0, bm[3:0]};
  assign nib_sub = {1'b0, am[3:0]} - {1'b0, bm[3:0]};

  always_comb begin
    case (op_i)
      3'b000:  res = add_full[W-1:0] & mask;
      3'b001:  res = sub_full[W-1:0] & mask;
      3'b010:  res = am & bm;
      3'b011:  res = am | bm;
      3'b100:  res = am ^ bm;
      default: res = '0;
    endcase
  end

  always_comb begin
    case (size_i)
      2'b00:   begin sa = am[7];     sb = bm[7];     sr = res[7];     add_c = add_full[8];   end
      2'b01:   begin sa = am[15];    sb = bm[15];    sr = res[15];    add_c = add_full[16];  end
      2'b10:   begin sa = am[4*Q-1]; sb = bm[4*Q-1]; sr = res[4*Q-1]; add_c = add_full[4*Q]; end
      default: begin sa = am[W-1];   sb = bm[W-1];   sr = res[W-1];   add_c = add_full[W];   end
    endcase
  end

  assign result_o = res;
  assign zero_o   = ~|res;
  assign sign_o   = sr;

  always_comb begin
    case (op_i)
      3'b000: begin
        carry_o = add_c;
        aux_o   = nib_add[4];
        ovf_o   = (sa == sb) && (sr != sa);
      end
      3'b001: begin
        carry_o = sub_full[W];
        aux_o   = nib_sub[4];
        ovf_o   = (sa != sb) && (sr != sa);
      end
      default: begin
        carry_o = 1'b0;
        aux_o   = 1'b0;
        ovf_o   = 1'b0;
      end
    endcase
  end
endmodule

module alu_flag_gen_chk #(
  parameter int W = 64
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [2:0]   op_i,
  input logic [1:0]   size_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         aux_o,
  input logic         zero_o,
  input logic         sign_o,
  input logic         ovf_o
);
  int unsigned n;
  logic [W-1:0] hi;
  always_comb begin
    n  = 8 << size_i;
    hi = (n >= W) ? '0 : ({W{1'b1}} << n);
    // R1
    upper_clear_chk: assert ((result_o & hi) == '0);
    // R7
    zero_match_chk: assert (zero_o == (result_o == '0));
    // R8
    sign_match_chk: assert (sign_o == result_o[n-1]);
    // R11
    logic_flags_chk: assert (!(op_i inside {3'b010, 3'b011, 3'b100}) || (!carry_o && !aux_o && !ovf_o));
    // R12
    undef_op_chk: assert (!(op_i inside {3'b101, 3'b110, 3'b111}) || (zero_o && !carry_o && !ovf_o));
    // R9
    no_overflow_chk: assert (!(op_i == 3'b000 && a_i[n-1] != b_i[n-1]) || !ovf_o);
  end
endmodule

bind alu_flag_gen alu_flag_gen_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu_flag_gen.sv
module sim_alu_flag_gen;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] a, b, res;
  logic [2:0]  op;
  logic [1:0]  sz;
  logic c, ax, z, s, v;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  alu_flag_gen u0 (.a_i(a), .b_i(b), .op_i(op), .size_i(sz), .result_o(res),
                   .carry_o(c), .aux_o(ax), .zero_o(z), .sign_o(s), .ovf_o(v));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s op=%0d sz=%0d a=%h b=%h actual=%h expected=%h", tag, op, sz, a, b, act, exp);
    end
  endtask

  task automatic run(logic [2:0] o, logic [1:0] w, logic [63:0] x, logic [63:0] y);
    int n;
    logic [63:0] m, ua, ub, er;
    logic [65:0] full;
    logic signed [67:0] sa, sbv, sr, lim;
    logic ec, eax, ev;
    n = 8 << w;
    m = (n == 64) ? '1 : ((64'd1 << n) - 1);
    ua = x & m; ub = y & m;
    ec = 0; eax = 0; ev = 0;
    sa  = $signed({4'b0, ua}); sbv = $signed({4'b0, ub});
    if (ua[n-1]) sa  = sa  - (68'sd1 <<< n);
    if (ub[n-1]) sbv = sbv - (68'sd1 <<< n);
    lim = 68'sd1 <<< (n - 1);
    case (o)
      3'd0: begin
        full = {2'b0, ua} + {2'b0, ub};
        er = full[63:0] & m;
        ec = (full >> n) != 0;
        eax = (ua[3:0] + ub[3:0]) > 15;
        sr = sa + sbv; ev = (sr >= lim) || (sr < -lim);
      end
      3'd1: begin
        er = (ua - ub) & m;
        ec = ua < ub;
        eax = ua[3:0] < ub[3:0];
        sr = sa - sbv; ev = (sr >= lim) || (sr < -lim);
      end
      3'd2: er = ua & ub;
      3'd3: er = ua | ub;
      3'd4: er = ua ^ ub;
      default: er = '0;
    endcase
    op = o; sz = w; a = x; b = y;
    #1;
    chk("R1/R2/R3/R11/R12 result", res, er);
    if (o == 0) begin chk("R4 carry", {63'd0, c}, {63'd0, ec}); chk("R9 ovf", {63'd0, v}, {63'd0, ev}); end
    else if (o == 1) begin chk("R5 borrow", {63'd0, c}, {63'd0, ec}); chk("R10 ovf", {63'd0, v}, {63'd0, ev}); end
    else begin chk("R11 carry", {63'd0, c}, 64'd0); chk("R11 ovf", {63'd0, v}, 64'd0); end
    chk("R6 aux", {63'd0, ax}, {63'd0, eax});
    chk("R7 zero", {63'd0, z}, {63'd0, er == 0});
    chk("R8 sign", {63'd0, s}, {63'd0, er[n-1]});
  endtask

  initial begin
    logic [63:0] pats [0:7];
    pats[0] = 64'h0; pats[1] = 64'h1; pats[2] = 64'h7FFF_FFFF_FFFF_FFFF; pats[3] = 64'h8000_0000_0000_0000;
    pats[4] = 64'hFFFF_FFFF_FFFF_FFFF; pats[5] = 64'h0000_7FFF_8000_7FFF; pats[6] = 64'h0000_0000_8000_0000;
    pats[7] = 64'h1234_5678_9ABC_DEF0;
    // R12 reset-like idle state: undefined opcode, zero operands
    run(3'd7, 2'd0, 64'h0, 64'h0);
    // R9 stated example: 0x7F + 0x01 at 8 bits
    run(3'd0, 2'd0, 64'h7F, 64'h01);
    chk("R9 example result", res, 64'h80);
    chk("R9 example ovf", {63'd0, v}, 64'd1);
    // exhaustive 8-bit sweep, garbage in upper bits (R2 masking)
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 256; i++)
        for (int j = 0; j < 256; j++)
          run(o[2:0], 2'd0, {56'hA5A5_5A5A_C3C3_3C, i[7:0]} ^ {i[7:0], 56'h0},
              {56'h0F0F_F0F0_1234_56, j[7:0]});
    // boundary patterns at every width
    for (int o = 0; o < 8; o++)
      for (int w = 0; w < 4; w++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            run(o[2:0], w[1:0], pats[i], pats[j]);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int k = 0; k < 190000; k++) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule